// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and a 64K x 8 asynchronous static RAM. The host issues one read or one write at a time over a valid/ready handshake. The controller then runs the RAM's control pins through a timed sequence. The RAM has a low-true select, a high-true select, a low-true output enable and a low-true write enable. When a transaction finishes, the controller raises a one-cycle done pulse. On a read, the fetched byte is on the read-data port during that pulse.

Each sequence is built from cycle counts. The clock period (in picoseconds) and a speed-grade parameter set these counts. A timing minimum is divided by the period, rounded up, and never allowed below one cycle. The fast grade needs a 55 ns read or write cycle, a 40 ns write pulse, 45 ns from select and from address to the end of the write, and 25 ns of data setup. The slow grade needs 70, 50, 60 and 30 ns. The RAM may keep driving the data pins for 20 ns (fast) or 25 ns (slow) after write enable falls or after it is deselected. The controller keeps its own drivers off for that interval.

The data bus is split into an outgoing byte, its drive enable and an incoming byte, so the pad tristate stays outside the block.

Top module: `sram_ctl`

## Requirements
- R1: During reset and whenever ready is high, the pins are idle: low-true select at 1, high-true select at 0, output enable at 1, write enable at 1, drive enable at 0. Done is 0 at reset.
- R2: A read holds both selects active, output enable at 0 and write enable at 1 for exactly ceil(tRC/Tclk) cycles. This is 11 cycles at the fast grade with a 5 ns clock. The drive enable stays 0 throughout.
- R3: The read byte is sampled on the last cycle of the read window. It is shown on the read-data port while done is high.
- R4: A write holds both selects active and output enable at 1. It holds write enable at 0 for the largest of: the write pulse, select-to-end, address-to-end, turnaround-plus-data-setup, and write-cycle-minus-one counts. This is 10 cycles at the fast grade with a 5 ns clock.
- R5: In a write, the drive enable stays 0 for the first ceil(tHZ/Tclk) cycles of write enable low (4 at the fast grade, 5 ns). It is 1 for the rest of the low interval.
- R6: Write enable rises one cycle before the drive enable falls. Both selects stay active in that hold cycle, and the write-data byte is driven on the rising edge of write enable.
- R7: The RAM address changes only while write enable is high.
- R8: Ready is 0 from acceptance until the transaction ends. Done is high for exactly one cycle and only together with ready. A request presented while ready is 0 is ignored and changes no RAM location.
- R9: Reset during a transaction returns the pins to idle at once. It discards the transaction, so no done follows for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host byte address |
| req_wdata | input | 8 | Host write byte |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| rsp_done | output | 1 | One-cycle end-of-transaction pulse |
| rsp_rdata | output | 8 | Byte fetched by the last read |
| ram_addr | output | 16 | RAM address pins |
| ram_sel_n | output | 1 | Low-true RAM select |
| ram_sel | output | 1 | High-true RAM select |
| ram_oe_n | output | 1 | Low-true RAM output enable |
| ram_we_n | output | 1 | Low-true RAM write enable |
| ram_dq_out | output | 8 | Byte to drive onto the RAM data pins |
| ram_dq_oe | output | 1 | Drive enable for the RAM data pins |
| ram_dq_in | input | 8 | Byte sampled from the RAM data pins |

## Verification
The hardest case to reach is a request arriving while the controller is busy. From the ports it looks the same as a request that will be accepted a moment later. The stimulus pulses a write request to a location that already holds known data, and only while ready is low. It drops the request before the current write ends. A later read of that location then shows whether the request slipped through. A reset issued in the middle of a read window is also driven. The bench then watches for a stray done pulse. A behavioural RAM model in the bench commits data only on the rising edge of write enable. It also measures every write-enable-low and output-enable-low window against counts worked out from the timing rules.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WLOW, ST_WHOLD} st_t;

  typedef enum int {TM_RC, TM_WC, TM_WP, TM_CW, TM_AW, TM_DS, TM_HZ} tm_t;

  // minimum interval in picoseconds for the selected speed grade
  function automatic int tmin_ps(input bit slow, input tm_t which);
    case (which)
      TM_RC:   return slow ? 70000 : 55000;
      TM_WC:   return slow ? 70000 : 55000;
      TM_WP:   return slow ? 50000 : 40000;
      TM_CW:   return slow ? 60000 : 45000;
      TM_AW:   return slow ? 60000 : 45000;
      TM_DS:   return slow ? 30000 : 25000;
      default: return slow ? 25000 : 20000;
    endcase
  endfunction

  function automatic int to_cyc(input int ps, input int per_ps);
    int c;
    c = (ps + per_ps - 1) / per_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC = 11,
  parameter int WL_CYC = 10,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  output st_t              st,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  st_t              st_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             done_nxt;

  always_comb begin
    st_nxt   = st;
    cnt_nxt  = cnt + CNT_W'(1);
    done_nxt = 1'b0;
    case (st)
      ST_IDLE: begin
        cnt_nxt = '0;
        if (start) st_nxt = start_wr ? ST_WLOW : ST_READ;
      end
      ST_READ: begin
        if (cnt == CNT_W'(RD_CYC - 1)) begin
          st_nxt   = ST_IDLE;
          cnt_nxt  = '0;
          done_nxt = 1'b1;
        end
      end
      ST_WLOW: begin
        if (cnt == CNT_W'(WL_CYC - 1)) begin
          st_nxt  = ST_WHOLD;
          cnt_nxt = '0;
        end
      end
      default: begin
        st_nxt   = ST_IDLE;
        cnt_nxt  = '0;
        done_nxt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      st   <= st_nxt;
      cnt  <= cnt_nxt;
      done <= done_nxt;
    end
  end

  // R8: done only on the cycle the sequencer has returned to idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == ST_IDLE));

  // R2: a read window always runs to its last count before leaving
  a_r2_read_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ) && (cnt != CNT_W'(RD_CYC - 1)) |=> (st == ST_READ));

endmodule

// File: rtl/sram_ctl_io.sv
module sram_ctl_io
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 11,
  parameter int HZ_CYC = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  st_t               st,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              sel_n,
  output logic              sel,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] rdata
);

  logic active;
  logic capture;

  assign active  = (st != ST_IDLE);
  assign sel_n   = ~active;
  assign sel     = active;
  assign oe_n    = ~(st == ST_READ);
  assign we_n    = ~(st == ST_WLOW);
  assign dq_oe   = ((st == ST_WLOW) && (cnt >= CNT_W'(HZ_CYC))) || (st == ST_WHOLD);
  assign capture = (st == ST_READ) && (cnt == CNT_W'(RD_CYC - 1));

  // address and write byte are loaded only at acceptance (write enable high)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      dq_out <= '0;
    end else if (load) begin
      addr   <= addr_in;
      dq_out <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= dq_in;
  end

  // R7: address frozen while write enable is low
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n && $past(!we_n) |-> $stable(addr));

  // R5: no drive on the first write-enable-low cycle
  a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> !dq_oe);

  // R6: data still driven when write enable rises
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe && !sel_n && sel);

  // R2: never drive while the RAM output is enabled
  a_r2_no_contend: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe && we_n);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 5000,
  parameter bit SLOW_GRADE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_sel_n,
  output logic              ram_sel,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int RD_CYC = to_cyc(tmin_ps(SLOW_GRADE, TM_RC), CLK_PS);
  localparam int HZ_CYC = to_cyc(tmin_ps(SLOW_GRADE, TM_HZ), CLK_PS);
  localparam int WP_CYC = to_cyc(tmin_ps(SLOW_GRADE, TM_WP), CLK_PS);
  localparam int CW_CYC = to_cyc(tmin_ps(SLOW_GRADE, TM_CW), CLK_PS);
  localparam int AW_CYC = to_cyc(tmin_ps(SLOW_GRADE, TM_AW), CLK_PS);
  localparam int DS_CYC = to_cyc(tmin_ps(SLOW_GRADE, TM_DS), CLK_PS);
  localparam int WC_CYC = to_cyc(tmin_ps(SLOW_GRADE, TM_WC), CLK_PS);
  localparam int WL_CYC = max2(max2(max2(WP_CYC, CW_CYC), max2(AW_CYC, HZ_CYC + DS_CYC)),
                               WC_CYC - 1);
  localparam int CNT_W  = $clog2(max2(RD_CYC, WL_CYC)) + 1;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_ctl_seq #(
    .RD_CYC (RD_CYC),
    .WL_CYC (WL_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (req_write),
    .st       (st),
    .cnt      (cnt),
    .done     (rsp_done)
  );

  sram_ctl_io #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RD_CYC (RD_CYC),
    .HZ_CYC (HZ_CYC),
    .CNT_W  (CNT_W)
  ) u_io (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .st       (st),
    .cnt      (cnt),
    .dq_in    (ram_dq_in),
    .addr     (ram_addr),
    .dq_out   (ram_dq_out),
    .dq_oe    (ram_dq_oe),
    .sel_n    (ram_sel_n),
    .sel      (ram_sel),
    .oe_n     (ram_oe_n),
    .we_n     (ram_we_n),
    .rdata    (rsp_rdata)
  );

  // R1: idle pins whenever ready
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ram_sel_n && !ram_sel && ram_oe_n && ram_we_n && !ram_dq_oe);

  // R8: done pulse is one cycle wide and comes with ready
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready ##1 !rsp_done);

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write;
  logic [15:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_ready, rsp_done;
  logic [7:0] rsp_rdata;
  logic [15:0] ram_addr;
  logic       ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0] ram_dq_out, ram_dq_in;

  // fast grade, 5 ns clock: expected counts from the timing rules
  localparam int EXP_RD = 11;  // 55/5
  localparam int EXP_WL = 10;  // max(8,9,9,4+5,11-1)
  localparam int EXP_HZ = 4;   // 20/5

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sram_ctl u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  // behavioural RAM
  logic [7:0] mem [int];
  logic selected;
  assign selected  = !ram_sel_n && ram_sel;
  assign ram_dq_in = (selected && !ram_oe_n && ram_we_n) ?
                     (mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00) : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge ram_we_n) begin
    if (rst_n && selected) begin
      check(ram_dq_oe, "R6 data driven at write-enable rise", ram_dq_oe, 1);
      if (ram_dq_oe) mem[int'(ram_addr)] = ram_dq_out;
    end
  end

  // scoreboard
  bit         exp_rd [$];
  logic [7:0] exp_d  [$];

  task automatic do_op(input bit wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exp_rd.push_back(!wr);
    exp_d.push_back(d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || exp_rd.size() != 0) @(negedge clk);
  endtask

  // monitor: done/rdata against queue, window lengths, handshake
  int  wl_cnt, rd_cnt, wl_windows;
  bit  prev_done;
  always @(negedge clk) begin
    if (!rst_n) begin
      wl_cnt = 0; rd_cnt = 0; prev_done = 0;
    end else begin
      if (rsp_done) begin
        check(req_ready, "R8 ready with done", req_ready, 1);
        check(!prev_done, "R8 done one cycle", prev_done, 0);
        if (exp_rd.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          bit rd; logic [7:0] d;
          rd = exp_rd.pop_front();
          d  = exp_d.pop_front();
          if (rd) check(rsp_rdata == d, "R3 read data", rsp_rdata, d);
        end
      end
      prev_done = rsp_done;
      if (!ram_we_n) begin
        if (wl_cnt < EXP_HZ)
          check(!ram_dq_oe, "R5 no drive in turnaround", ram_dq_oe, 0);
        else
          check(ram_dq_oe, "R5 drive after turnaround", ram_dq_oe, 1);
        check(selected && ram_oe_n, "R4 selects on, oe off in write",
              {ram_sel_n, ram_sel, ram_oe_n}, 3'b011);
        wl_cnt++;
      end else if (wl_cnt != 0) begin
        check(wl_cnt == EXP_WL, "R4 write-enable low length", wl_cnt, EXP_WL);
        check(selected && ram_dq_oe, "R6 hold cycle", {selected, ram_dq_oe}, 2'b11);
        wl_windows++;
        wl_cnt = 0;
      end
      if (!ram_oe_n) begin
        check(selected && ram_we_n && !ram_dq_oe, "R2 read pins",
              {selected, ram_we_n, ram_dq_oe}, 3'b110);
        rd_cnt++;
      end else if (rd_cnt != 0) begin
        check(rd_cnt == EXP_RD, "R2 read window length", rd_cnt, EXP_RD);
        rd_cnt = 0;
      end
    end
  end

  task automatic check_idle(input string req);
    check(ram_sel_n && !ram_sel && ram_oe_n && ram_we_n && !ram_dq_oe && req_ready,
          req, {ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe, req_ready}, 6'b101101);
  endtask

  initial begin
    wl_windows = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 reset pins");
    check(!rsp_done, "R1 done low at reset", rsp_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after reset");

    // writes then reads, several patterns
    do_op(1, 16'h0000, 8'hA5);
    do_op(1, 16'hFFFF, 8'h3C);
    do_op(1, 16'h1234, 8'h5A);
    do_op(0, 16'h0000, 8'hA5);
    do_op(0, 16'h1234, 8'h5A);
    do_op(0, 16'hFFFF, 8'h3C);
    do_op(1, 16'h8001, 8'h00);
    do_op(0, 16'h8001, 8'h00);
    do_op(1, 16'h8001, 8'hFF);
    do_op(0, 16'h8001, 8'hFF);
    wait_idle();
    check(wl_windows == 5, "R4 write window count", wl_windows, 5);

    // R8: request pulsed while busy must be ignored
    do_op(1, 16'h4000, 8'h11);
    check(!req_ready, "R8 ready low while busy", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1234; req_wdata = 8'hEE;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    do_op(0, 16'h1234, 8'h5A);
    do_op(0, 16'h4000, 8'h11);
    wait_idle();

    // R9: reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R9 idle on reset mid-read");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check_idle("R9 idle after discarded read");
    do_op(0, 16'hFFFF, 8'h3C);
    wait_idle();

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule